// File: doc/BRIEF.md
# Prioritised Local Interrupt Selector

This block decides whether a hart should take one of its local interrupts, and which one. Each cycle it takes the pending and enable vectors, a per-source delegation mask, the hart's current privilege level, and the global machine and supervisor interrupt-enable bits. A source is a candidate only when it is both pending and enabled.

Each candidate is then checked against the level it would trap to. A source whose delegation bit is clear traps to machine level. A source whose delegation bit is set traps to supervisor level. A target level can be interrupted when the hart runs below it, or when the hart runs at that level with that level's global enable set. Among the candidates that pass, the lowest-numbered one is reported.

The result is registered, so the take flag and the cause number appear one clock after the inputs. The trap sequence itself and the updating of pending bits belong to the surrounding core.

Top module: `lirq_selector`

## Requirements
- R1: A source is eligible only when both its pending bit and its enable bit are 1. A source with either bit at 0 is never reported.
- R2: A non-delegated source (delegation bit 0) is taken when the privilege is U (code 0) or S (code 1), whatever the machine enable says. It is also taken at M (code 3) when the machine enable is 1.
- R3: At privilege M with the machine enable at 0, no source is taken, delegated or not.
- R4: A delegated source (delegation bit 1) is taken at U regardless of the supervisor enable. At S it is taken only when the supervisor enable is 1. At M it is never taken.
- R5: When several sources survive, cause_o is the index of the lowest-numbered survivor, where bit 0 is index 0.
- R6: When no source survives, take_o is 0 and cause_o is 0.
- R7: Outputs are registered. The result for the inputs present at a rising clock edge appears after that edge. A synchronous active-high reset forces take_o to 0 and cause_o to 0.
- R8: Privilege is a 2-bit code: U=0, S=1, M=3. Code 2 is never presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | NUM_SRC | Pending bit per source |
| en_i | input | NUM_SRC | Enable bit per source |
| deleg_i | input | NUM_SRC | 1 routes the source to supervisor level, 0 to machine level |
| priv_i | input | 2 | Current privilege: U=0, S=1, M=3 |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | CAUSE_W | Index of the selected source |

## Verification
The hardest case to reach is a lower-numbered source that is pending and enabled but gated off by its delegation target, while a higher-numbered source routed to the other level survives. In that case the pick must skip the lower candidate. Pure random vectors rarely produce this with a meaningful privilege and enable setting. Directed vectors therefore split low and high bits across the delegation mask at each privilege, and random vectors draw sparse pending masks so that gating decides the winner often.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/lirq_level_gate.sv
module lirq_level_gate
  import lirq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic [NUM_SRC-1:0] qual_o
);
  logic m_open;
  logic s_open;
  logic [NUM_SRC-1:0] cand;

  always_comb begin
    m_open = (priv_i != PRIV_M) || m_gie_i;
    s_open = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && s_gie_i);
    cand   = pend_i & en_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign qual_o[g] = cand[g] & (deleg_i[g] ? s_open : m_open);
  end
endmodule

// File: rtl/lirq_lowest_pick.sv
module lirq_lowest_pick #(
  parameter int NUM_SRC = 16,
  localparam int CAUSE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = CAUSE_W'(i);
    end
  end
endmodule

// File: rtl/lirq_selector.sv
module lirq_selector
  import lirq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int CAUSE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_SRC-1:0] qual_w;
  logic               any_w;
  logic [CAUSE_W-1:0] idx_w;

  lirq_level_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .pend_i (pend_i),
    .en_i   (en_i),
    .deleg_i(deleg_i),
    .priv_i (priv_i),
    .m_gie_i(m_gie_i),
    .s_gie_i(s_gie_i),
    .qual_o (qual_w)
  );

  lirq_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .vec_i(qual_w),
    .any_o(any_w),
    .idx_o(idx_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o  <= 1'b0;
      cause_o <= '0;
    end else begin
      take_o  <= any_w;
      cause_o <= any_w ? idx_w : '0;
    end
  end

  logic [NUM_SRC-1:0] below_mask;
  assign below_mask = ~({NUM_SRC{1'b1}} << cause_o);

  // A survivor must be pending and enabled.
  assert_qual_subset_R1: assert property (@(posedge clk) disable iff (rst)
    (qual_w & ~(pend_i & en_i)) == '0);

  // Machine level closed: nothing survives.
  assert_m_closed_R3: assert property (@(posedge clk) disable iff (rst)
    (priv_i == PRIV_M && !m_gie_i) |-> (qual_w == '0));

  // Delegated sources never survive while running at machine level.
  assert_deleg_at_m_R4: assert property (@(posedge clk) disable iff (rst)
    (priv_i == PRIV_M) |-> ((qual_w & deleg_i) == '0));

  // The reported cause was a candidate one cycle earlier.
  assert_cause_was_pending_R1: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((($past(pend_i & en_i) >> cause_o) & NUM_SRC'(1)) != '0));

  // No lower-numbered survivor existed.
  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (($past(qual_w) & below_mask) == '0));

  // Idle output carries cause zero.
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (cause_o == '0));
endmodule

// File: tb/tb_lirq_selector.sv
module tb_lirq_selector;
  localparam int NUM_SRC = 16;
  localparam int CAUSE_W = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 100000;

  logic               clk = 1'b0;
  logic               rst;
  logic [NUM_SRC-1:0] pend_i, en_i, deleg_i;
  logic [1:0]         priv_i;
  logic               m_gie_i, s_gie_i;
  logic               take_o;
  logic [CAUSE_W-1:0] cause_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lirq_selector #(.NUM_SRC(NUM_SRC)) dut (
    .clk(clk), .rst(rst), .pend_i(pend_i), .en_i(en_i), .deleg_i(deleg_i),
    .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
    .take_o(take_o), .cause_o(cause_o)
  );

  function automatic logic [CAUSE_W:0] model(
    input logic [NUM_SRC-1:0] p, e, d, input logic [1:0] pr,
    input logic mg, input logic sg);
    logic m_ok, s_ok, keep;
    m_ok = (pr == 2'd0) || (pr == 2'd1) || (pr == 2'd3 && mg);
    s_ok = (pr == 2'd0) || (pr == 2'd1 && sg);
    for (int i = 0; i < NUM_SRC; i++) begin
      keep = p[i] && e[i] && (d[i] ? s_ok : m_ok);
      if (keep) return {1'b1, CAUSE_W'(i)};
    end
    return '0;
  endfunction

  task automatic check(input string req, input logic exp_t, input logic [CAUSE_W-1:0] exp_c);
    vectors++;
    if (take_o !== exp_t || cause_o !== exp_c) begin
      errors++;
      $display("FAIL %s: take/cause got %0b/%0d expected %0b/%0d", req, take_o, cause_o, exp_t, exp_c);
    end
  endtask

  task automatic apply(input string req, input logic [NUM_SRC-1:0] p, e, d,
                       input logic [1:0] pr, input logic mg, input logic sg);
    logic [CAUSE_W:0] exp;
    pend_i = p; en_i = e; deleg_i = d; priv_i = pr; m_gie_i = mg; s_gie_i = sg;
    exp = model(p, e, d, pr, mg, sg);
    @(posedge clk);
    @(negedge clk);
    check(req, exp[CAUSE_W], exp[CAUSE_W-1:0]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [1:0] pr;
    seed = 32'h1A2B;
    void'($urandom(seed));
    rst = 1'b1;
    pend_i = '1; en_i = '1; deleg_i = '0; priv_i = 2'd0; m_gie_i = 1'b1; s_gie_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset", 1'b0, '0);
    rst = 1'b0;

    // R1: enable gating and pending gating
    apply("R1", 16'h00F0, 16'h0F00, 16'h0000, 2'd0, 1'b0, 1'b0);
    apply("R1", 16'h0300, 16'h0200, 16'h0000, 2'd3, 1'b1, 1'b0);
    // R2: machine-routed at each privilege
    apply("R2", 16'h0080, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    apply("R2", 16'h0080, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0);
    apply("R2", 16'h0080, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0);
    // R3: machine closed
    apply("R3", 16'hFFFF, 16'hFFFF, 16'h00FF, 2'd3, 1'b0, 1'b1);
    // R4: supervisor-routed
    apply("R4", 16'h0020, 16'hFFFF, 16'h0020, 2'd0, 1'b0, 1'b0);
    apply("R4", 16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1'b1, 1'b0);
    apply("R4", 16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1'b0, 1'b1);
    apply("R4", 16'h0020, 16'hFFFF, 16'h0020, 2'd3, 1'b1, 1'b1);
    // R5: low bit gated off by delegation, higher survives
    apply("R5", 16'h8003, 16'hFFFF, 16'h0003, 2'd1, 1'b1, 1'b0);
    apply("R5", 16'h8003, 16'hFFFF, 16'h8000, 2'd3, 1'b1, 1'b1);
    apply("R5", 16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    apply("R5", 16'h8000, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    // R6: nothing survives
    apply("R6", 16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1);
    // R7: reset in mid-run clears outputs
    apply("R7", 16'h0010, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 mid reset", 1'b0, '0);
    rst = 1'b0;

    // R8: random vectors using only legal privilege codes
    for (int n = 0; n < 2000; n++) begin
      logic [NUM_SRC-1:0] p;
      case ($urandom_range(0, 2))
        0: pr = 2'd0;
        1: pr = 2'd1;
        default: pr = 2'd3;
      endcase
      p = NUM_SRC'($urandom) & NUM_SRC'($urandom);
      apply("R8 random", p, NUM_SRC'($urandom), NUM_SRC'($urandom), pr,
            1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule